// File: doc/BRIEF.md
# Shared Exclusive-Access Reservation Monitor

This block tracks exclusive-access reservations for a group of processors that share memory. It holds one reservation entry per processor, each made of an open/exclusive flag and an address tag. Processors send three kinds of request: a reserving load, a plain store and a conditional store. Each request carries an address. The block answers every conditional store with a pass or fail verdict, which tells the requesting processor whether its store may commit. The block does no memory access itself.

All requests pass through one round-robin arbiter, which grants one processor per cycle. The granted operation is applied to every entry in a single clock edge, so each operation is atomic with respect to all the others. A processor keeps its request raised until it sees its grant bit. The response, tagged with the processor number, appears one cycle after the grant. Tags are compared at granule resolution: the low `GRAN_LSB` address bits are ignored. A per-processor clear input drops that processor's reservation, for example when the processor is taken offline.

Top module: `xmon_global`

## Requirements
- R1: After reset every entry is open with a zero tag. `grant` and `rsp_vld` are low, and a conditional store from any processor fails.
- R2: At most one grant bit is high per cycle, and only for a processor whose `req_vld` is high. The search starts at the processor after the last one granted and wraps, starting from processor 0 after reset.
- R3: Every grant is followed in the next cycle by `rsp_vld` high, with `rsp_id` equal to the granted processor number. With no grant, `rsp_vld` is low in the next cycle.
- R4: A reserving load (op 2'b00) from processor P makes P's entry exclusive with the masked address as its tag, and leaves every other entry unchanged.
- R5: A plain store (op 2'b01) from any processor opens every exclusive entry whose tag equals the masked store address, including the storer's own entry. Entries with other tags are unchanged.
- R6: A conditional store (op 2'b10) from P passes only if P's entry is exclusive and its tag equals the masked address; the comparison ignores the low `GRAN_LSB` bits. A pass opens P's entry.
- R7: A passing conditional store opens every other processor's exclusive entry whose tag matches.
- R8: A failing conditional store, whether P's entry is open or its tag differs, changes no entry. A later matching conditional store from the reservation holder still passes.
- R9: `clr[i]` high forces entry i open at the next edge. This takes priority over a granted operation, and the other entries are unaffected.
- R10: Op 2'b11 is granted and answered with `rsp_pass` low, and it changes no entry.
- R11: `rsp_pass` is high only in the response to a conditional store. Reserving loads and plain stores answer with `rsp_pass` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | NPROC | Request raised by each processor, held until granted |
| req_op | input | 2*NPROC | Operation per processor, 2 bits each (00 load-reserve, 01 store, 10 conditional store, 11 none) |
| req_addr | input | NPROC*AW | Address per processor, AW bits each |
| grant | output | NPROC | One-hot grant for this cycle |
| clr | input | NPROC | Force a processor's entry open |
| rsp_vld | output | 1 | Response valid, one cycle after a grant |
| rsp_id | output | IDW | Processor that the response belongs to |
| rsp_pass | output | 1 | Conditional store verdict |

## Verification
The bench builds the block with three processors, a 16-bit address and a 4-byte granule. Three processors is not a power of two, so the round-robin pointer must wrap from the last index back to zero rather than overflow. It also lets three-way reservation sharing be arranged: two holders on one granule and a bystander on another. The small granule puts a same-granule, different-byte address and a neighbouring-granule address within a few counts of each other, which exercises the tag mask at both of its edges.

// File: rtl/xmon_global.sv
module xmon_global #(
  parameter int NPROC    = 4,
  parameter int AW       = 32,
  parameter int GRAN_LSB = 3,
  localparam int IDW     = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPROC-1:0]      req_vld,
  input  logic [2*NPROC-1:0]    req_op,
  input  logic [NPROC*AW-1:0]   req_addr,
  output logic [NPROC-1:0]      grant,
  input  logic [NPROC-1:0]      clr,
  output logic                  rsp_vld,
  output logic [IDW-1:0]        rsp_id,
  output logic                  rsp_pass
);

  localparam logic [1:0] OP_LDR = 2'b00;
  localparam logic [1:0] OP_ST  = 2'b01;
  localparam logic [1:0] OP_STC = 2'b10;
  localparam logic [AW-1:0] GMASK = {AW{1'b1}} << GRAN_LSB;

  logic [NPROC-1:0] excl_q;
  logic [AW-1:0]    tag_q [NPROC];
  logic [IDW-1:0]   ptr_q;
  logic [IDW-1:0]   gid;
  logic             any_g;
  logic [1:0]       g_op;
  logic [AW-1:0]    g_tag;
  logic [NPROC-1:0] hit;
  logic [NPROC-1:0] kill;
  logic             stc_pass;

  always_comb begin
    any_g = 1'b0;
    gid   = '0;
    for (int k = 0; k < NPROC; k++) begin
      if (!any_g && req_vld[(int'(ptr_q) + k) % NPROC]) begin
        any_g = 1'b1;
        gid   = IDW'((int'(ptr_q) + k) % NPROC);
      end
    end
  end

  assign grant    = any_g ? (NPROC'(1) << gid) : '0;
  assign g_op     = req_op[2*int'(gid) +: 2];
  assign g_tag    = req_addr[int'(gid)*AW +: AW] & GMASK;
  assign stc_pass = any_g && (g_op == OP_STC) && hit[gid];
  assign kill     = (any_g && (g_op == OP_ST || stc_pass)) ? hit : '0;

  generate
    for (genvar i = 0; i < NPROC; i++) begin : g_ent
      assign hit[i] = excl_q[i] && (tag_q[i] == g_tag);

      always_ff @(posedge clk) begin
        if (!rst_n || clr[i] || kill[i]) begin
          excl_q[i] <= 1'b0;
          tag_q[i]  <= '0;
        end else if (any_g && g_op == OP_LDR && int'(gid) == i) begin
          excl_q[i] <= 1'b1;
          tag_q[i]  <= g_tag;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      rsp_vld  <= 1'b0;
      rsp_id   <= '0;
      rsp_pass <= 1'b0;
    end else begin
      rsp_vld  <= any_g;
      rsp_pass <= stc_pass;
      if (any_g) begin
        rsp_id <= gid;
        ptr_q  <= (int'(gid) == NPROC - 1) ? '0 : gid + IDW'(1);
      end
    end
  end

endmodule

module xmon_global_chk #(
  parameter int NPROC = 4,
  parameter int IDW   = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NPROC-1:0]     req_vld,
  input logic [2*NPROC-1:0]   req_op,
  input logic [NPROC-1:0]     grant,
  input logic [NPROC-1:0]     clr,
  input logic                 rsp_vld,
  input logic [IDW-1:0]       rsp_id,
  input logic                 rsp_pass,
  input logic [NPROC-1:0]     excl_q
);
  logic [IDW-1:0] c_gid;
  logic [1:0]     c_op;

  always_comb begin
    c_gid = '0;
    c_op  = 2'b00;
    for (int k = 0; k < NPROC; k++) begin
      if (grant[k]) begin
        c_gid = IDW'(k);
        c_op  = req_op[2*k +: 2];
      end
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2
  AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req_vld) == '0); // R2
  AST_RSP_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> (rsp_vld && rsp_id == $past(c_gid))); // R3
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|grant) |=> !rsp_vld); // R3
  AST_PASS_STC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grant) && c_op != 2'b10) |=> !rsp_pass); // R11
  AST_CLR_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr) |=> ((excl_q & $past(clr)) == '0)); // R9
endmodule

bind xmon_global xmon_global_chk #(.NPROC(NPROC), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_op(req_op),
  .grant(grant), .clr(clr), .rsp_vld(rsp_vld), .rsp_id(rsp_id),
  .rsp_pass(rsp_pass), .excl_q(excl_q)
);

// File: tb/xmon_global_tb_top.sv
`timescale 1ns/1ps
module xmon_global_tb_top;
  localparam int NPROC = 3;
  localparam int AW    = 16;
  localparam int GL    = 2;
  localparam int IDW   = 2;
  localparam logic [1:0] LDR = 2'b00, ST = 2'b01, STC = 2'b10, NOP = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPROC-1:0] req_vld = '0;
  logic [2*NPROC-1:0] req_op = '0;
  logic [NPROC*AW-1:0] req_addr = '0;
  logic [NPROC-1:0] grant;
  logic [NPROC-1:0] clr = '0;
  logic rsp_vld;
  logic [IDW-1:0] rsp_id;
  logic rsp_pass;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  xmon_global #(.NPROC(NPROC), .AW(AW), .GRAN_LSB(GL)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_op(req_op),
    .req_addr(req_addr), .grant(grant), .clr(clr), .rsp_vld(rsp_vld),
    .rsp_id(rsp_id), .rsp_pass(rsp_pass)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_vld = '0; clr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_op(input int p, input logic [1:0] c, input logic [AW-1:0] a,
                       output logic ps);
    @(negedge clk);
    req_vld[p] = 1'b1;
    req_op[2*p +: 2] = c;
    req_addr[p*AW +: AW] = a;
    #1;
    while (!grant[p]) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    req_vld[p] = 1'b0;
    chk(rsp_vld === 1'b1 && int'(rsp_id) == p, "R3 rsp id", int'(rsp_id), p);
    ps = rsp_pass;
    if (c != STC) chk(ps === 1'b0, "R11 pass on non-conditional op", int'(ps), 0);
  endtask

  task automatic expect_stc(input int p, input logic [AW-1:0] a, input bit exp, input string r);
    logic ps;
    do_op(p, STC, a, ps);
    chk(ps === exp, r, int'(ps), int'(exp));
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk(grant == '0, "R1 grant idle", int'(grant), 0);
    chk(rsp_vld === 1'b0, "R1 rsp idle", int'(rsp_vld), 0);
    for (int p = 0; p < NPROC; p++) expect_stc(p, 16'h0000, 1'b0, "R1 stc after reset");
    @(negedge clk);
    chk(rsp_vld === 1'b0, "R3 no rsp without grant", int'(rsp_vld), 0);
  endtask

  task automatic t_reserve();
    logic ps;
    do_reset();
    do_op(0, LDR, 16'h0100, ps);
    expect_stc(1, 16'h0100, 1'b0, "R4 other entry untouched");
    expect_stc(0, 16'h0100, 1'b1, "R6 own stc passes");
    expect_stc(0, 16'h0100, 1'b0, "R6 pass opens own entry");
  endtask

  task automatic t_granule();
    logic ps;
    do_reset();
    do_op(0, LDR, 16'h0040, ps);
    expect_stc(0, 16'h0043, 1'b1, "R6 same granule matches");
    do_op(0, LDR, 16'h0040, ps);
    expect_stc(0, 16'h0044, 1'b0, "R6 next granule mismatches");
    expect_stc(0, 16'h0040, 1'b1, "R8 mismatch fail kept reservation");
  endtask

  task automatic t_store();
    logic ps;
    do_reset();
    do_op(0, LDR, 16'h0200, ps);
    do_op(1, LDR, 16'h0201, ps);
    do_op(2, LDR, 16'h0300, ps);
    do_op(1, ST, 16'h0202, ps);
    expect_stc(0, 16'h0200, 1'b0, "R5 store clears other holder");
    expect_stc(1, 16'h0200, 1'b0, "R5 store clears own entry");
    expect_stc(2, 16'h0300, 1'b1, "R5 other tag unaffected");
  endtask

  task automatic t_broadcast();
    logic ps;
    do_reset();
    do_op(0, LDR, 16'h0500, ps);
    do_op(1, LDR, 16'h0500, ps);
    do_op(2, LDR, 16'h0600, ps);
    expect_stc(0, 16'h0500, 1'b1, "R7 first holder passes");
    expect_stc(1, 16'h0500, 1'b0, "R7 second holder cleared");
    expect_stc(2, 16'h0600, 1'b1, "R7 other tag kept");
    do_op(0, LDR, 16'h0700, ps);
    do_op(1, LDR, 16'h0700, ps);
    expect_stc(2, 16'h0700, 1'b0, "R8 open entry fails");
    expect_stc(0, 16'h0700, 1'b1, "R8 failed stc cleared nobody");
  endtask

  task automatic t_clear();
    logic ps;
    do_reset();
    do_op(1, LDR, 16'h0800, ps);
    do_op(0, LDR, 16'h0800, ps);
    @(negedge clk); clr[1] = 1'b1;
    @(negedge clk); clr[1] = 1'b0;
    expect_stc(1, 16'h0800, 1'b0, "R9 cleared entry fails");
    expect_stc(0, 16'h0800, 1'b1, "R9 other entry kept");
  endtask

  task automatic t_nop();
    logic ps;
    do_reset();
    do_op(0, LDR, 16'h0900, ps);
    do_op(1, NOP, 16'h0900, ps);
    chk(ps === 1'b0, "R10 nop verdict", int'(ps), 0);
    expect_stc(0, 16'h0900, 1'b1, "R10 nop left entry");
  endtask

  task automatic t_arb();
    do_reset();
    @(negedge clk);
    req_vld = '1;
    req_op = {NOP, NOP, NOP};
    for (int k = 0; k < NPROC; k++) begin
      #1;
      chk(grant == NPROC'(1 << k), "R2 round robin order", int'(grant), 1 << k);
      @(negedge clk);
      req_vld[k] = 1'b0;
    end
    #1;
    chk(grant == '0, "R2 no grant without request", int'(grant), 0);
    do_reset();
    @(negedge clk);
    req_vld = 3'b010;
    #1;
    chk(grant == 3'b010, "R2 lone request", int'(grant), 2);
    @(negedge clk);
    req_vld = 3'b011;
    #1;
    chk(grant == 3'b001, "R2 wrap to processor 0", int'(grant), 1);
    @(negedge clk);
    req_vld[0] = 1'b0;
    #1;
    chk(grant == 3'b010, "R2 held request served", int'(grant), 2);
    @(negedge clk);
    req_vld = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_reserve();
    t_granule();
    t_store();
    t_broadcast();
    t_clear();
    t_nop();
    t_arb();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule